// File: doc/BRIEF.md
# Subroutine Return Stack Unit

This block keeps the return addresses of a small 8-bit microcontroller core in a last-in, first-out store. It also keeps a shadow copy of the working register (W), the status register and the bank-select register. A call pushes a program-counter value into the store. A return instruction pops the newest entry and hands it to the core as the next program counter.

The return instruction carries a fast-restore bit. When that bit is set, the core's three architectural registers are reloaded from the shadow copies, using the same pop. The shadow copies are refreshed by a single-clock capture strobe, which the core raises on interrupt entry or on a fast call.

The unit runs a three-state sequencer:

- **IDLE** accepts a return instruction.
  - IDLE→FLUSH is taken when a return arrives with no push pending, and the pop happens at that edge.
  - IDLE→DEFER is taken when a return arrives together with a push.
- **DEFER** holds the pop off while a push is requested.
  - DEFER→DEFER is taken while `push_req` stays high.
  - DEFER→FLUSH is taken when `push_req` drops, and the pop happens then.
- **FLUSH** is the second instruction cycle, which discards the already fetched word.
  - FLUSH→IDLE is always taken after one cycle.

Top module: `ret_stack_unit`

## Requirements
- R1: After reset, `stack_ptr` is 0 and `underflow`, `busy`, `pc_load`, `restore_we` and `pc_value` are all 0.
- R2: A return is recognised only when `instr_valid` is high in IDLE and `instr_word[15:1]` equals 15'h0009 (words 16'h0012 and 16'h0013). Any other word, or a return word with `instr_valid` low, leaves all outputs unchanged.
- R3: A push stores `push_addr` and raises `stack_ptr` by one. When `stack_ptr` is 31 (full), a push is ignored and the contents are kept.
- R4: One cycle after a return is popped, `pc_load` is high for one cycle and `pc_value` holds the most recently pushed address. At the same time `stack_ptr` drops by one, so entries come back in last-in, first-out order.
- R5: A return occupies two cycles. `busy` is high only in the FLUSH cycle (and during DEFER). Return words presented while `busy` is high are ignored.
- R6: With `instr_word[0]`=1 (fast), `restore_we` is high together with `pc_load`, and `w_out`, `status_out` and `bsr_out` carry the shadow copies.
- R7: With `instr_word[0]`=0, `restore_we` stays low, so W, STATUS and BSR keep their values and no flag changes.
- R8: A `shadow_cap` pulse copies `w_in`, `status_in` and `bsr_in` into the shadow set in one clock. A pop restores the shadow contents as they stood before that pop's edge, so a capture at the same edge counts only for later returns.
- R9: A pop with `stack_ptr` at 0 gives `pc_value` 0, keeps `stack_ptr` at 0 and sets `underflow`. `underflow` stays set until reset.
- R10: If a return and `push_req` arrive in the same cycle, the push is done first. The pop waits for as long as `push_req` stays high and then returns the address just pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | `instr_word` holds a decoded instruction |
| instr_word | input | 16 | Instruction word; bit 0 is the fast-restore flag |
| push_req | input | 1 | Push `push_addr` onto the stack |
| push_addr | input | 21 | Return address to store |
| shadow_cap | input | 1 | Copy W/STATUS/BSR into the shadow set |
| w_in | input | 8 | Current W |
| status_in | input | 8 | Current STATUS |
| bsr_in | input | 8 | Current BSR |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | 21 | Popped return address |
| restore_we | output | 1 | Write W/STATUS/BSR from the outputs below |
| w_out | output | 8 | Shadow W to restore |
| status_out | output | 8 | Shadow STATUS to restore |
| bsr_out | output | 8 | Shadow BSR to restore |
| busy | output | 1 | Return in progress (DEFER or FLUSH) |
| stack_ptr | output | 5 | Number of stored entries |
| underflow | output | 1 | Sticky: a pop found the stack empty |

## Verification
Inputs sampled at a clock edge show up one cycle later:

- The stack pointer after a push.
- The shadow-capture effect.
- `busy`, `pc_load`, `pc_value` and `restore_we` after an accepted return.
- `underflow` after an empty pop.

When a push collides with a return, the pop's results slip by one cycle for each cycle `push_req` is held. The bench model advances on the same edge as the design and compares every output 2 ns after each rising edge, with inputs changed only on falling edges. Every result is therefore compared in the exact cycle it is due.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    localparam int unsigned INSTR_W = 16;

    // upper fifteen bits of the return opcode; bit 0 is the fast flag
    localparam logic [INSTR_W-2:0] RET_OPCODE = 15'h0009;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_FLUSH = 2'd2
    } rs_state_e;

    function automatic logic is_return(input logic [INSTR_W-1:0] word);
        return word[INSTR_W-1:1] == RET_OPCODE;
    endfunction

endpackage

// File: rtl/rs_lifo.sv
module rs_lifo #(
    parameter int DEPTH  = 31,
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_data,
    input  logic              pop_en,
    output logic [ADDR_W-1:0] pop_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              underflow
);

    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  top_idx;
    logic              can_push;
    logic              empty;

    assign top_idx  = ptr - 1'b1;
    assign can_push = push_en && (ptr != FULL_CNT);
    assign empty    = (ptr == '0);

    always_ff @(posedge clk) begin
        if (can_push) begin
            mem[ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            underflow <= 1'b0;
            pop_data  <= '0;
        end else if (can_push) begin
            ptr <= ptr + 1'b1;
        end else if (pop_en && !push_en) begin
            if (empty) begin
                underflow <= 1'b1;
                pop_data  <= '0;
            end else begin
                pop_data <= mem[top_idx];
                ptr      <= top_idx;
            end
        end
    end

endmodule

// File: rtl/rs_shadow.sv
module rs_shadow #(
    parameter int DATA_W = 8,
    parameter int NREG   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_en,
    input  logic [NREG-1:0][DATA_W-1:0]  arch_in,
    input  logic                         snap_en,
    output logic [NREG-1:0][DATA_W-1:0]  snap_out
);

    logic [NREG-1:0][DATA_W-1:0] shadow_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[g] <= '0;
                snap_out[g] <= '0;
            end else begin
                if (cap_en) begin
                    shadow_q[g] <= arch_in[g];
                end
                if (snap_en) begin
                    snap_out[g] <= shadow_q[g];
                end
            end
        end
    end

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import ret_stack_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               push_req,
    output logic               do_push,
    output logic               do_pop,
    output rs_state_e          state,
    output logic               fast_q
);

    rs_state_e state_nx;
    logic      ret_hit;

    assign ret_hit = instr_valid && is_return(instr_word) && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            fast_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (ret_hit) begin
                fast_q <= instr_word[0];
            end
        end
    end

    always_comb begin
        state_nx = state;
        do_push  = push_req;
        do_pop   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ret_hit) begin
                    if (push_req) begin
                        state_nx = ST_DEFER;
                    end else begin
                        do_pop   = 1'b1;
                        state_nx = ST_FLUSH;
                    end
                end
            end
            ST_DEFER: begin
                if (!push_req) begin
                    do_pop   = 1'b1;
                    state_nx = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
                do_push  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ret_stack_unit.sv
module ret_stack_unit
    import ret_stack_pkg::*;
#(
    parameter  int DEPTH  = 31,
    parameter  int ADDR_W = 21,
    parameter  int DATA_W = 8,
    localparam int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               push_req,
    input  logic [ADDR_W-1:0]  push_addr,
    input  logic               shadow_cap,
    input  logic [DATA_W-1:0]  w_in,
    input  logic [DATA_W-1:0]  status_in,
    input  logic [DATA_W-1:0]  bsr_in,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  pc_value,
    output logic               restore_we,
    output logic [DATA_W-1:0]  w_out,
    output logic [DATA_W-1:0]  status_out,
    output logic [DATA_W-1:0]  bsr_out,
    output logic               busy,
    output logic [PTR_W-1:0]   stack_ptr,
    output logic               underflow
);

    localparam int NSHADOW = 3;

    rs_state_e                      state;
    logic                           do_push;
    logic                           do_pop;
    logic                           fast_q;
    logic [NSHADOW-1:0][DATA_W-1:0] arch_bus;
    logic [NSHADOW-1:0][DATA_W-1:0] snap_bus;

    rs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .push_req    (push_req),
        .do_push     (do_push),
        .do_pop      (do_pop),
        .state       (state),
        .fast_q      (fast_q)
    );

    rs_lifo #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W)
    ) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (do_push),
        .push_data (push_addr),
        .pop_en    (do_pop),
        .pop_data  (pc_value),
        .ptr       (stack_ptr),
        .underflow (underflow)
    );

    assign arch_bus = {bsr_in, status_in, w_in};

    rs_shadow #(
        .DATA_W (DATA_W),
        .NREG   (NSHADOW)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (shadow_cap),
        .arch_in  (arch_bus),
        .snap_en  (do_pop),
        .snap_out (snap_bus)
    );

    assign w_out      = snap_bus[0];
    assign status_out = snap_bus[1];
    assign bsr_out    = snap_bus[2];

    assign pc_load    = (state == ST_FLUSH);
    assign restore_we = pc_load && fast_q;
    assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/ret_stack_unit_chk.sv
module ret_stack_unit_chk #(
    parameter int DEPTH = 31,
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic             pc_load,
    input logic             restore_we,
    input logic             busy,
    input logic [PTR_W-1:0] stack_ptr,
    input logic             underflow
);

    // R2: a return cycle only begins after a valid instruction
    a_r2_busy_needs_instr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_valid));

    // R3: the pointer never passes the depth
    a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ptr <= PTR_W'(DEPTH));

    // R4: a load follows a pointer decrement or an empty pop
    a_r4_pop_moves_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (($past(stack_ptr) == stack_ptr + 1'b1) ||
                     (underflow && stack_ptr == '0)));

    // R5: the flush cycle is the last one of the return
    a_r5_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    // R6: restoring only goes together with a pc load
    a_r6_restore_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        restore_we |-> pc_load);

    // R9: underflow is sticky
    a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

endmodule

bind ret_stack_unit ret_stack_unit_chk #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .pc_load     (pc_load),
    .restore_we  (restore_we),
    .busy        (busy),
    .stack_ptr   (stack_ptr),
    .underflow   (underflow)
);

// File: tb/ret_stack_unit_tb_top.sv
module ret_stack_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        push_req = 1'b0;
    logic [20:0] push_addr = '0;
    logic        shadow_cap = 1'b0;
    logic [7:0]  w_in = '0, status_in = '0, bsr_in = '0;
    logic        pc_load, restore_we, busy, underflow;
    logic [20:0] pc_value;
    logic [7:0]  w_out, status_out, bsr_out;
    logic [4:0]  stack_ptr;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    ret_stack_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .push_req(push_req), .push_addr(push_addr), .shadow_cap(shadow_cap),
        .w_in(w_in), .status_in(status_in), .bsr_in(bsr_in),
        .pc_load(pc_load), .pc_value(pc_value), .restore_we(restore_we),
        .w_out(w_out), .status_out(status_out), .bsr_out(bsr_out),
        .busy(busy), .stack_ptr(stack_ptr), .underflow(underflow)
    );

    // behavioural reference model
    logic [20:0] m_stack[$];
    int          m_phase = 0;    // 0 idle, 1 waiting on push, 2 flush
    bit          m_fast = 0, m_uf = 0;
    logic [20:0] m_pc = '0;
    logic [7:0]  m_sh[3] = '{8'h0, 8'h0, 8'h0};
    logic [7:0]  m_sn[3] = '{8'h0, 8'h0, 8'h0};

    task automatic check(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (during %s) %s actual=%0h expected=%0h", req, phase, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit do_push, do_pop;
        do_push = push_req;
        do_pop  = 0;
        case (m_phase)
            0: if (instr_valid && instr_word[15:1] == 15'h0009) begin
                   m_fast = instr_word[0];
                   if (push_req) m_phase = 1;
                   else begin do_pop = 1; m_phase = 2; end
               end
            1: if (!push_req) begin do_pop = 1; m_phase = 2; end
            default: m_phase = 0;
        endcase
        if (do_push) begin
            if (m_stack.size() < 31) m_stack.push_back(push_addr);
        end else if (do_pop) begin
            m_sn = m_sh;
            if (m_stack.size() == 0) begin m_uf = 1; m_pc = '0; end
            else m_pc = m_stack.pop_back();
        end
        if (shadow_cap) m_sh = '{w_in, status_in, bsr_in};
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stack.delete();
            m_phase = 0; m_fast = 0; m_uf = 0; m_pc = '0;
            m_sh = '{8'h0, 8'h0, 8'h0};
            m_sn = '{8'h0, 8'h0, 8'h0};
        end else begin
            model_step();
        end
        started = 1;
        #2;
        check("R3", "stack_ptr", stack_ptr, m_stack.size());
        check("R4", "pc_load", pc_load, m_phase == 2);
        check("R4", "pc_value", pc_value, m_pc);
        check("R5", "busy", busy, m_phase != 0);
        check("R6", "restore_we", restore_we, (m_phase == 2) && m_fast);
        check("R8", "w_out", w_out, m_sn[0]);
        check("R8", "status_out", status_out, m_sn[1]);
        check("R8", "bsr_out", bsr_out, m_sn[2]);
        check("R9", "underflow", underflow, m_uf);
    end

    task automatic drive(bit v, logic [15:0] wd, bit p, logic [20:0] a, bit c,
                         logic [7:0] w, logic [7:0] s, logic [7:0] b);
        @(negedge clk);
        instr_valid = v; instr_word = wd; push_req = p; push_addr = a;
        shadow_cap = c; w_in = w; status_in = s; bsr_in = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 16'h0, 0, '0, 0, 8'h0, 8'h0, 8'h0);
    endtask

    task automatic ret(bit fast);
        drive(1, {15'h0009, fast}, 0, '0, 0, 8'h0, 8'h0, 8'h0);
        idle(2);
    endtask

    task automatic check_reset();
        // R1 explicit reset-state checks
        check("R1", "stack_ptr", stack_ptr, 0);
        check("R1", "underflow", underflow, 0);
        check("R1", "busy", busy, 0);
        check("R1", "pc_load", pc_load, 0);
        check("R1", "restore_we", restore_we, 0);
        check("R1", "pc_value", pc_value, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        idle(2);

        phase = "R2";   // near-miss words and invalid return
        drive(1, 16'h0010, 0, '0, 0, 0, 0, 0);
        drive(1, 16'h0014, 0, '0, 0, 0, 0, 0);
        drive(1, 16'h8012, 0, '0, 0, 0, 0, 0);
        drive(0, 16'h0012, 0, '0, 0, 0, 0, 0);
        idle(2);

        phase = "R3";
        for (int i = 0; i < 5; i++) drive(0, 16'h0, 1, 21'h10000 + 21'(i * 3), 0, 0, 0, 0);
        idle(1);

        phase = "R8";
        drive(0, 16'h0, 0, '0, 1, 8'hA5, 8'h1C, 8'h03);
        idle(1);

        phase = "R7";
        ret(0);
        phase = "R6";
        ret(1);

        phase = "R10";  // return colliding with a two-cycle push
        drive(1, 16'h0013, 1, 21'h1ABCD, 0, 0, 0, 0);
        drive(0, 16'h0, 1, 21'h0F0F0, 0, 0, 0, 0);
        idle(3);

        phase = "R8";   // capture at the same edge as a fast pop
        drive(1, 16'h0013, 0, '0, 1, 8'h5A, 8'hE1, 8'h0F);
        idle(2);
        ret(1);

        phase = "R3";   // overfill
        for (int i = 0; i < 35; i++) drive(0, 16'h0, 1, 21'h1F000 + 21'(i), 0, 0, 0, 0);
        idle(1);

        phase = "R5";   // back-to-back return words, every second one flushed
        for (int i = 0; i < 70; i++) drive(1, 16'h0012, 0, '0, 0, 0, 0, 0);
        idle(2);

        phase = "R9";
        ret(1);
        ret(0);
        drive(0, 16'h0, 1, 21'h00777, 0, 0, 0, 0);
        idle(1);
        ret(0);

        phase = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        idle(3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule